// File: doc/BRIEF.md
# Line Buffer Write Address Generator

This block produces the destination memory addresses for the pixel lines that a camera receiver delivers for one capture context. Software programs three holding registers: the first buffer base, the second buffer base and a signed line stride. At every frame-start sync event those values are copied into the working state. The generator then emits 32-byte burst addresses through each line and works out where the following line must begin.

The stride is held in 32-byte units. A stride of zero packs lines back to back, so each line begins where the previous one's data ended. A nonzero stride places each line at the previous line's start plus the stride. Negative strides give bottom-up storage. All arithmetic wraps modulo 2^32.

When the two base addresses differ, successive frames alternate between them, starting with the first buffer after enable. When the two bases are equal, every frame lands in the same buffer. One instance serves one context; a chip with eight contexts places eight instances, each decoded at its own 0x20-byte window of the register map.

Top module: `line_wr_addr_gen`

## Requirements
- R1: After reset, burstValid is 0 and every register select reads back zero. A frame started without any prior register write places line 0 at address 0.
- R2: Register select encoding is 0 = stride, 1 = first base, 2 = second base, 3 = unused (reads 0). Base registers keep bits 31:5 and read bits 4:0 as zero. The stride register keeps bits 16:5 and reads bits 31:17 and 4:0 as zero.
- R3: Register writes change the generated addresses only from the next frame-start sync onward. Lines already inside the current frame keep the values loaded at its start.
- R4: With a zero stride, line k of a frame starts at base + k * L, where L is lineBytes with bits 4:0 cleared.
- R5: With a nonzero stride, line k starts at base + k * S. S is bits 16:5 of the stride register, taken as a signed 17-bit byte value with bits 4:0 zero. The sum wraps modulo 2^32.
- R6: A lineStart pulse raises burstValid on the next cycle for L/32 accepted bursts. The first address is the line start and each accepted burst (burstValid and burstReady) adds 32. While a burst is not accepted, burstValid and burstAddr hold.
- R7: When the two base registers differ, the first frame after enable uses the first base, and successive frames alternate between the second and first bases.
- R8: When the two base registers are equal, every frame uses that base.
- R9: A lineStart pulse while bursts of the current line are still pending is ignored: the line continues and the next line start is unaffected.
- R10: While ctxEnable is low, frame and line syncs are ignored and pending bursts are dropped (burstValid falls). Re-enabling restarts buffer selection at the first base.
- R11: A frame-start sync during a line discards that line's remaining bursts. If it coincides with lineStart, the frame start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctxEnable | input | 1 | Context enable |
| frameStart | input | 1 | Frame-start sync pulse |
| lineStart | input | 1 | Line-start pulse |
| lineBytes | input | 16 | Bytes per line; bits 4:0 ignored |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Holding register read data |
| burstValid | output | 1 | Burst address valid |
| burstReady | input | 1 | Burst accepted by bus master |
| burstAddr | output | 32 | Burst destination byte address |

## Verification
The bench sweeps positive, negative, extreme and zero strides against two line lengths and three frames. The first base sits near the top of the address space, so a design that dropped the carry or failed to sign-extend the stride lands lines at wrong addresses. Base registers are rewritten mid-frame: a design that loaded them at once would move the remaining lines of that frame. A design that decided double buffering from stale values would mis-toggle on the frame after the rewrite. Syncs are also pulsed while a line is pending or the context is off. A design that let these through would restart the line, lose its place in the line sequence, or keep bursts alive after disable.

// File: rtl/lwag_pkg.sv
package lwag_pkg;

  // Register selection codes for the per-context window
  typedef enum logic [1:0] {
    SEL_STRIDE = 2'd0,
    SEL_FIRST  = 2'd1,
    SEL_SECOND = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // Strobes issued by control to the datapath
  typedef struct packed {
    logic loadFrame;  // copy holding registers and pick frame base
    logic useSecond;  // base chosen for the frame being loaded
    logic startLine;  // begin a line at the precomputed head
    logic stepBurst;  // a burst was accepted
  } lwagStrobes_t;

endpackage

// File: rtl/lwag_ctrl.sv
module lwag_ctrl
  import lwag_pkg::*;
#(
  parameter int LG = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctxEnable,
  input  logic          frameStart,
  input  logic          lineStart,
  input  logic [LG-1:0] lenGran,
  input  logic          dualBuf,
  input  logic          burstReady,
  output lwagStrobes_t  strobes,
  output logic          burstValid
);

  logic [LG-1:0] remaining;
  logic          bufSel;
  logic          firstFrame;

  assign burstValid = (remaining != '0);

  always_comb begin
    strobes.loadFrame = ctxEnable & frameStart;
    strobes.useSecond = firstFrame ? 1'b0 : (dualBuf ? ~bufSel : 1'b0);
    strobes.startLine = ctxEnable & lineStart & ~frameStart & ~burstValid;
    strobes.stepBurst = ctxEnable & ~frameStart & burstValid & burstReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining  <= '0;
      bufSel     <= 1'b0;
      firstFrame <= 1'b1;
    end else if (!ctxEnable) begin
      remaining  <= '0;
      bufSel     <= 1'b0;
      firstFrame <= 1'b1;
    end else if (strobes.loadFrame) begin
      remaining  <= '0;
      bufSel     <= strobes.useSecond;
      firstFrame <= 1'b0;
    end else if (strobes.startLine) begin
      remaining  <= lenGran;
    end else if (strobes.stepBurst) begin
      remaining  <= remaining - 1'b1;
    end
  end

  // R6: an offered burst stays offered until accepted
  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctxEnable && burstValid && !burstReady && !frameStart |=> burstValid);

  // R7: buffer choice moves only at an enabled frame start
  assert_buf_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctxEnable && !frameStart |=> $stable(bufSel));

  // R8: equal bases never select the second buffer
  assert_single_buf_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctxEnable && frameStart && !dualBuf |=> !bufSel);

endmodule

// File: rtl/lwag_dpath.sv
module lwag_dpath
  import lwag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ALIGN_W  = 5,
  parameter int STRIDE_W = 17,
  parameter int LG       = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lwagStrobes_t              strobes,
  input  logic                      regWrEn,
  input  logic [1:0]                regSel,
  input  logic [ADDR_W-ALIGN_W-1:0] wrGran,
  input  logic [LG-1:0]             lenGran,
  output logic [ADDR_W-1:0]         regRdData,
  output logic                      dualBuf,
  output logic [ADDR_W-1:0]         burstAddr
);

  localparam int G  = ADDR_W - ALIGN_W;    // address width in 32-byte granules
  localparam int SG = STRIDE_W - ALIGN_W;  // stride width in granules

  logic [SG-1:0] holdStride;
  logic [G-1:0]  holdFirst;
  logic [G-1:0]  holdSecond;
  logic [SG-1:0] actStride;
  logic [G-1:0]  nextHead;
  logic [G-1:0]  curAddr;
  logic [G-1:0]  lineStep;

  regSel_e selE;
  assign selE = regSel_e'(regSel);

  assign dualBuf = (holdFirst != holdSecond);

  // Step to the following line: packed when stride is zero
  always_comb begin
    if (actStride == '0) lineStep = {{(G-LG){1'b0}}, lenGran};
    else                 lineStep = {{(G-SG){actStride[SG-1]}}, actStride};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdStride <= '0;
      holdFirst  <= '0;
      holdSecond <= '0;
    end else if (regWrEn) begin
      case (selE)
        SEL_STRIDE: holdStride <= wrGran[SG-1:0];
        SEL_FIRST:  holdFirst  <= wrGran;
        SEL_SECOND: holdSecond <= wrGran;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actStride <= '0;
      nextHead  <= '0;
      curAddr   <= '0;
    end else if (strobes.loadFrame) begin
      actStride <= holdStride;
      nextHead  <= strobes.useSecond ? holdSecond : holdFirst;
    end else if (strobes.startLine) begin
      curAddr   <= nextHead;
      nextHead  <= nextHead + lineStep;
    end else if (strobes.stepBurst) begin
      curAddr   <= curAddr + 1'b1;
    end
  end

  always_comb begin
    case (selE)
      SEL_STRIDE: regRdData = {{(ADDR_W-STRIDE_W){1'b0}}, holdStride, {ALIGN_W{1'b0}}};
      SEL_FIRST:  regRdData = {holdFirst, {ALIGN_W{1'b0}}};
      SEL_SECOND: regRdData = {holdSecond, {ALIGN_W{1'b0}}};
      default:    regRdData = '0;
    endcase
  end

  assign burstAddr = {curAddr, {ALIGN_W{1'b0}}};

  // R6: address holds when no strobe moves it
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stepBurst && !strobes.startLine |=> $stable(burstAddr));

endmodule

// File: rtl/line_wr_addr_gen.sv
module line_wr_addr_gen
  import lwag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ALIGN_W  = 5,
  parameter int STRIDE_W = 17,
  parameter int LEN_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctxEnable,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic [LEN_W-1:0]  lineBytes,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic              burstValid,
  input  logic              burstReady,
  output logic [ADDR_W-1:0] burstAddr
);

  localparam int LG = LEN_W - ALIGN_W;

  lwagStrobes_t  strobes;
  logic          dualBuf;
  logic [LG-1:0] lenGran;
  logic          lowBitsUnused;

  assign lenGran       = lineBytes[LEN_W-1:ALIGN_W];
  assign lowBitsUnused = ^{lineBytes[ALIGN_W-1:0], regWrData[ALIGN_W-1:0]};

  lwag_ctrl #(.LG(LG)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctxEnable (ctxEnable),
    .frameStart(frameStart),
    .lineStart (lineStart),
    .lenGran   (lenGran),
    .dualBuf   (dualBuf),
    .burstReady(burstReady),
    .strobes   (strobes),
    .burstValid(burstValid)
  );

  lwag_dpath #(
    .ADDR_W  (ADDR_W),
    .ALIGN_W (ALIGN_W),
    .STRIDE_W(STRIDE_W),
    .LG      (LG)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .wrGran   (regWrData[ADDR_W-1:ALIGN_W]),
    .lenGran  (lenGran),
    .regRdData(regRdData),
    .dualBuf  (dualBuf),
    .burstAddr(burstAddr)
  );

endmodule

// File: tb/line_wr_addr_gen_tb_top.sv
module line_wr_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctxEnable;
  logic        frameStart;
  logic        lineStart;
  logic [15:0] lineBytes;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        burstValid;
  logic        burstReady;
  logic [31:0] burstAddr;

  int vecCnt  = 0;
  int failCnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  line_wr_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .ctxEnable(ctxEnable), .frameStart(frameStart),
    .lineStart(lineStart), .lineBytes(lineBytes), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .burstValid(burstValid), .burstReady(burstReady), .burstAddr(burstAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vecCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] sxStride(input logic [31:0] d);
    return {{15{d[16]}}, d[16:5], 5'b0};
  endfunction

  task automatic wrReg(input logic [1:0] sel, input logic [31:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] sel, input logic [31:0] exp, input string req);
    regSel = sel;
    #1;
    chk(regRdData == exp, req, regRdData, exp);
  endtask

  task automatic pulseFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic restart();
    ctxEnable = 1'b0;
    @(negedge clk);
    ctxEnable = 1'b1;
  endtask

  // Run one line and check every burst address; optional stall on burst 0
  task automatic runLine(input logic [31:0] start, input int nb, input bit stall,
                         input string req);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    for (int i = 0; i < nb; i++) begin
      chk(burstValid == 1'b1, "R6 valid", {31'b0, burstValid}, 32'd1);
      chk(burstAddr == start + 32'(32 * i), req, burstAddr, start + 32'(32 * i));
      if (stall && i == 0) begin
        @(negedge clk);
        chk(burstValid == 1'b1, "R6 stall valid", {31'b0, burstValid}, 32'd1);
        chk(burstAddr == start, "R6 stall addr", burstAddr, start);
      end
      burstReady = 1'b1;
      @(negedge clk);
      burstReady = 1'b0;
    end
    chk(burstValid == 1'b0, "R6 end of line", {31'b0, burstValid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] strideSet [6];
    logic [31:0] firstB;
    logic [31:0] secondB;
    logic [31:0] base;
    logic [31:0] step;
    logic [31:0] lbA;
    int          nb;

    rstN = 1'b0; ctxEnable = 1'b0; frameStart = 1'b0; lineStart = 1'b0;
    lineBytes = 16'd64; regWrEn = 1'b0; regSel = 2'd0; regWrData = '0;
    burstReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    ctxEnable = 1'b1;

    // R1: reset state
    chk(burstValid == 1'b0, "R1 valid", {31'b0, burstValid}, 32'd0);
    for (int s = 0; s < 4; s++) rdChk(2'(s), 32'd0, "R1 readback");
    pulseFrame();
    runLine(32'd0, 2, 1'b0, "R1 default base");

    // R2: field positions and reserved bits
    wrReg(2'd1, 32'hFFFF_FFFF);
    wrReg(2'd2, 32'h1234_5678);
    wrReg(2'd0, 32'hFFFF_FFFF);
    wrReg(2'd3, 32'hFFFF_FFFF);
    rdChk(2'd1, 32'hFFFF_FFE0, "R2 first base");
    rdChk(2'd2, 32'h1234_5660, "R2 second base");
    rdChk(2'd0, 32'h0001_FFE0, "R2 stride");
    rdChk(2'd3, 32'h0000_0000, "R2 unused select");

    // R4/R5/R7: sweep strides, lengths, frames, lines
    strideSet[0] = 32'h0000_0000;
    strideSet[1] = 32'h0000_0020;
    strideSet[2] = 32'h0001_FFE0;
    strideSet[3] = 32'h0000_FFE0;
    strideSet[4] = 32'h0001_0000;
    strideSet[5] = 32'h0000_0400;
    firstB  = 32'hFFFF_F000;
    secondB = 32'h0010_0020;
    wrReg(2'd1, firstB | 32'h1F);
    wrReg(2'd2, secondB);
    for (int si = 0; si < 6; si++) begin
      for (int li = 0; li < 2; li++) begin
        lineBytes = (li == 0) ? 16'd32 : 16'd103;
        lbA = {16'b0, lineBytes & 16'hFFE0};
        nb  = int'(lbA) / 32;
        wrReg(2'd0, (si % 2 == 1) ? (strideSet[si] | 32'hFFFE_001F) : strideSet[si]);
        restart();
        step = (strideSet[si] == 0) ? lbA : sxStride(strideSet[si]);
        for (int f = 0; f < 3; f++) begin
          pulseFrame();
          base = (f % 2 == 0) ? firstB : secondB;
          for (int k = 0; k < 3; k++) begin
            runLine(base + 32'(k) * step, nb, (k == 1),
                    (strideSet[si] == 0) ? "R4 packed line (R7 buffer)"
                                         : "R5 strided line (R7 buffer)");
          end
        end
      end
    end

    // R3 and R8: equal bases, mid-frame rewrite takes effect next frame
    lineBytes = 16'd64;
    wrReg(2'd1, 32'h0000_4000);
    wrReg(2'd2, 32'h0000_4000);
    wrReg(2'd0, 32'h0000_0100);
    restart();
    pulseFrame();
    runLine(32'h0000_4000, 2, 1'b0, "R3 line0 before rewrite");
    wrReg(2'd1, 32'h0000_8000);
    wrReg(2'd2, 32'h0000_8000);
    wrReg(2'd0, 32'h0000_0040);
    runLine(32'h0000_4100, 2, 1'b0, "R3 line1 keeps old values");
    for (int f = 0; f < 3; f++) begin
      pulseFrame();
      runLine(32'h0000_8000, 2, 1'b0, "R8 same buffer line0");
      runLine(32'h0000_8040, 2, 1'b0, "R8 same buffer line1 (R3 new stride)");
    end

    // R9: lineStart while pending is ignored
    pulseFrame();
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    burstReady = 1'b1;
    @(negedge clk);
    lineStart = 1'b1;
    burstReady = 1'b0;
    chk(burstAddr == 32'h0000_8020, "R9 second burst", burstAddr, 32'h0000_8020);
    @(negedge clk);
    lineStart = 1'b0;
    chk(burstValid == 1'b1, "R9 still pending", {31'b0, burstValid}, 32'd1);
    chk(burstAddr == 32'h0000_8020, "R9 addr kept", burstAddr, 32'h0000_8020);
    burstReady = 1'b1;
    @(negedge clk);
    burstReady = 1'b0;
    chk(burstValid == 1'b0, "R9 line ended", {31'b0, burstValid}, 32'd0);
    runLine(32'h0000_8040, 2, 1'b0, "R9 next line unaffected");

    // R11: frame start aborts a line, and wins over lineStart
    lineBytes = 16'd128;
    pulseFrame();
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    chk(burstValid == 1'b0, "R11 abort", {31'b0, burstValid}, 32'd0);
    frameStart = 1'b1;
    lineStart  = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    lineStart  = 1'b0;
    chk(burstValid == 1'b0, "R11 frame wins", {31'b0, burstValid}, 32'd0);
    runLine(32'h0000_8000, 4, 1'b0, "R11 line after frame");

    // R10: disable drops bursts and ignores syncs; re-enable restarts
    wrReg(2'd2, 32'h0000_C000);
    pulseFrame();
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    ctxEnable = 1'b0;
    @(negedge clk);
    chk(burstValid == 1'b0, "R10 dropped", {31'b0, burstValid}, 32'd0);
    frameStart = 1'b1;
    lineStart  = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    lineStart  = 1'b0;
    @(negedge clk);
    chk(burstValid == 1'b0, "R10 syncs ignored", {31'b0, burstValid}, 32'd0);
    ctxEnable = 1'b1;
    pulseFrame();
    runLine(32'h0000_8000, 4, 1'b0, "R10 restart at first base");
    pulseFrame();
    runLine(32'h0000_C000, 4, 1'b0, "R10 then second base");

    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule